// File: doc/BRIEF.md
# SDRAM Controller with Power-Up Sequencing and Periodic Refresh

This block controls a single rank of synchronous DRAM that is 64 bits wide and has four internal banks. After reset it holds the memory idle for a long settling period, precharges every bank, runs a series of auto-refresh commands and then programs the mode register. Only after that does it report itself ready. From then on it keeps the stored data alive with an auto-refresh at a fixed cycle interval. Between refreshes it serves one read or one write at a time, requested through a simple valid/acknowledge port.

Every access is a single word: a burst length of one, in sequential order. The controller opens the row, issues the column command and then precharges again, so no row stays open between requests. All waits are cycle counters. Their defaults come from nanosecond minimums at a 10 ns clock. A due refresh always wins over a waiting request. Read data is captured a programmable CAS latency of 2 or 3 cycles after the read command, and comes back on a one-cycle valid strobe.

Top module: `sdram_ctl`

## Requirements
- R1: While reset is high, and for at least INIT_CYCLES (default 10000) cycles after it is released, the command pins carry only NOP. `init_done` and `req_ready` stay low, and CKE is driven high once reset is released.
- R2: The initialization order is:
  - one precharge with A10 high;
  - then INIT_REFS (default 8) auto-refresh commands, each at least T_RC apart;
  - then a mode register load whose address bits carry: burst length 1 in bits 2:0 (code 000), sequential order in bit 3 (0), the CAS latency in bits 6:4, and zero in all other bits.

  No command follows the mode load for T_MRD (2) cycles. `init_done` rises only after the mode load and never falls.
- R3: Commands are encoded on {CS#,RAS#,CAS#,WE#} as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE LOAD 0000. No other code is driven.
- R4: The request address splits into a 12-bit row in bits 22:11, a 2-bit bank in bits 10:9 and a 9-bit column in bits 8:0. ACTIVE carries the row and bank; READ and WRITE carry the column and bank.
- R5: Row timing holds at the pins:
  - ACTIVE to READ or WRITE is at least T_RCD (3) cycles.
  - ACTIVE to PRECHARGE is at least T_RAS (6) cycles.
  - ACTIVE to ACTIVE is at least T_RC (9) cycles.
  - PRECHARGE to ACTIVE or REFRESH is at least T_RP (3) cycles.
  - WRITE to PRECHARGE is more than T_WR (1) cycle.
  - Every access ends with a PRECHARGE that has A10 high. READ and WRITE carry A10 low.
- R6: A WRITE carries its data, with the output enable high, in the same cycle as the command. The byte mask on that cycle is the inverse of the request byte enables, so bytes whose enable is clear keep their old contents. An all-zero enable changes nothing.
- R7: `rd_valid` pulses for one cycle, CAS_LAT+1 cycles after READ appears on the pins. It carries the data the memory presented CAS_LAT cycles after it sampled the READ. The byte mask is low on READ cycles.
- R8: After initialization, consecutive auto-refresh commands are no more than REF_INTERVAL (default 1560) plus 20 cycles apart, even under continuous request traffic.
- R9: A refresh that falls due is issued ahead of any waiting request. No ACTIVE follows a REFRESH within T_RC cycles.
- R10: `req_ready` is a single-cycle acknowledge. It is given once per accepted request, and only when `init_done` is high. A request held during initialization is accepted only after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {row, bank, column} |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Write byte enables, one per byte |
| req_ready | output | 1 | One-cycle acknowledge of an accepted request |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 64 | Captured read data |
| init_done | output | 1 | Initialization complete |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column address |
| sd_dqm | output | 8 | Byte masks |
| sd_dq_out | output | 64 | Data toward the memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 64 | Data from the memory |

## Verification
The assertions assume that a requester holds `req_valid` and its fields steady until it sees the acknowledge, and then drops it. The bench driver releases the request on the falling edge at which it first observes `req_ready`, and it never raises a new request in that same cycle.

The read-latency property also assumes that the memory returns data exactly CAS latency cycles after it samples READ. The behavioural memory in the bench drives `sd_dq_in` only in that window and drives a poison pattern otherwise, so a capture in the wrong cycle shows up as a data mismatch.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // Pin code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE_ALL,
    ST_INIT_REF,
    ST_MRS,
    ST_IDLE,
    ST_RW,
    ST_PRE_ROW
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdc_addr_map.sv
module sdc_addr_map #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col
);
  // Layout: {row, bank, column}, column in the least significant bits
  assign row  = addr[ADDR_W-1 -: ROW_W];
  assign bank = addr[COL_W +: BANK_W];
  assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
  parameter int REF_INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int TW = $clog2(REF_INTERVAL + 1);

  logic [TW-1:0] tick;
  logic          expire;

  assign expire = run && (tick == TW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      pending <= 1'b0;
    end else begin
      if (run) tick <= expire ? '0 : tick + 1'b1;
      if (expire)   pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_read_capture.sv
module sdc_read_capture #(
  parameter int CAS_LAT = 3,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issued,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  // pipe[j] set j+1 edges after READ sits on the pins
  logic [CAS_LAT-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe     <= (pipe << 1) | CAS_LAT'(rd_issued);
      rd_valid <= pipe[CAS_LAT-1];
      if (pipe[CAS_LAT-1]) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdc_sequencer.sv
module sdc_sequencer
  import sdc_pkg::*;
#(
  parameter int ROW_W       = 12,
  parameter int COL_W       = 9,
  parameter int BANK_W      = 2,
  parameter int DATA_W      = 64,
  parameter int BE_W        = DATA_W / 8,
  parameter int INIT_CYCLES = 10000,
  parameter int INIT_REFS   = 8,
  parameter int T_RCD       = 3,
  parameter int T_RP        = 3,
  parameter int T_RAS       = 6,
  parameter int T_RC        = 9,
  parameter int T_MRD       = 2,
  parameter int T_WR        = 1,
  parameter int CAS_LAT     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              ref_pending,
  output logic              ref_ack,
  output logic              req_ready,
  output logic              init_done,
  output sd_cmd_e           cmd_q,
  output logic              cke,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic [BE_W-1:0]   sd_dqm,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  // Spacing between command issue edges; every wait is at least 2
  localparam int W_RCD   = imax(T_RCD, 2);
  localparam int PRE_OFF = imax(T_RAS, W_RCD + T_WR + 1);
  localparam int W_RW    = imax(PRE_OFF - W_RCD, 2);
  localparam int W_PRE   = imax(imax(T_RP, T_RC - W_RCD - W_RW), 2);
  localparam int W_RP    = imax(T_RP, 2);
  localparam int W_RC    = imax(T_RC, 2);
  localparam int W_MRD   = imax(T_MRD, 2);
  localparam int CNT_W   = $clog2(imax(INIT_CYCLES, 64) + 1);
  localparam int RC_W    = $clog2(INIT_REFS + 1);
  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1 << 10);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  seq_state_e        state, ret_state;
  logic [CNT_W-1:0]  cnt;
  logic [RC_W-1:0]   ref_cnt;
  logic              lat_write;
  logic [COL_W-1:0]  lat_col;
  logic [BANK_W-1:0] lat_bank;
  logic [DATA_W-1:0] lat_wdata;
  logic [BE_W-1:0]   lat_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT;
      ret_state <= ST_PRE_ALL;
      cnt       <= CNT_W'(INIT_CYCLES);
      ref_cnt   <= '0;
      cmd_q     <= CMD_NOP;
      cke       <= 1'b0;
      sd_addr   <= '0;
      sd_ba     <= '0;
      sd_dqm    <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      init_done <= 1'b0;
      req_ready <= 1'b0;
      ref_ack   <= 1'b0;
      lat_write <= 1'b0;
      lat_col   <= '0;
      lat_bank  <= '0;
      lat_wdata <= '0;
      lat_be    <= '0;
    end else begin
      cke       <= 1'b1;
      cmd_q     <= CMD_NOP;
      dq_oe     <= 1'b0;
      sd_dqm    <= '0;
      req_ready <= 1'b0;
      ref_ack   <= 1'b0;
      case (state)
        ST_WAIT: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) state <= ret_state;
        end
        ST_PRE_ALL: begin
          cmd_q     <= CMD_PRE;
          sd_addr   <= ALL_BANKS;
          ref_cnt   <= '0;
          cnt       <= CNT_W'(W_RP - 1);
          state     <= ST_WAIT;
          ret_state <= ST_INIT_REF;
        end
        ST_INIT_REF: begin
          cmd_q     <= CMD_REF;
          ref_cnt   <= ref_cnt + 1'b1;
          cnt       <= CNT_W'(W_RC - 1);
          state     <= ST_WAIT;
          ret_state <= (ref_cnt == RC_W'(INIT_REFS - 1)) ? ST_MRS : ST_INIT_REF;
        end
        ST_MRS: begin
          cmd_q     <= CMD_MRS;
          sd_addr   <= MODE_WORD;
          sd_ba     <= '0;
          cnt       <= CNT_W'(W_MRD - 1);
          state     <= ST_WAIT;
          ret_state <= ST_IDLE;
        end
        ST_IDLE: begin
          init_done <= 1'b1;
          if (ref_pending) begin
            cmd_q     <= CMD_REF;
            ref_ack   <= 1'b1;
            cnt       <= CNT_W'(W_RC - 1);
            state     <= ST_WAIT;
            ret_state <= ST_IDLE;
          end else if (req_valid) begin
            cmd_q     <= CMD_ACT;
            sd_addr   <= req_row;
            sd_ba     <= req_bank;
            req_ready <= 1'b1;
            lat_write <= req_write;
            lat_col   <= req_col;
            lat_bank  <= req_bank;
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
            cnt       <= CNT_W'(W_RCD - 1);
            state     <= ST_WAIT;
            ret_state <= ST_RW;
          end
        end
        ST_RW: begin
          cmd_q       <= lat_write ? CMD_WR : CMD_RD;
          sd_addr     <= ROW_W'(lat_col);
          sd_addr[10] <= 1'b0;
          sd_ba       <= lat_bank;
          if (lat_write) begin
            dq_out <= lat_wdata;
            dq_oe  <= 1'b1;
            sd_dqm <= ~lat_be;
          end
          cnt       <= CNT_W'(W_RW - 1);
          state     <= ST_WAIT;
          ret_state <= ST_PRE_ROW;
        end
        ST_PRE_ROW: begin
          cmd_q     <= CMD_PRE;
          sd_addr   <= ALL_BANKS;
          cnt       <= CNT_W'(W_PRE - 1);
          state     <= ST_WAIT;
          ret_state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_ctl.sv
module sdram_ctl
  import sdc_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int BANK_W       = 2,
  parameter int DATA_W       = 64,
  parameter int BE_W         = DATA_W / 8,
  parameter int ADDR_W       = ROW_W + BANK_W + COL_W,
  parameter int INIT_CYCLES  = 10000,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RAS        = 6,
  parameter int T_RC         = 9,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 1,
  parameter int CAS_LAT      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BE_W-1:0]   sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  logic [ROW_W-1:0]  m_row;
  logic [BANK_W-1:0] m_bank;
  logic [COL_W-1:0]  m_col;
  logic              ref_pending, ref_ack;
  sd_cmd_e           cmd_q;

  sdc_addr_map #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_map (
    .addr(req_addr), .row(m_row), .bank(m_bank), .col(m_col)
  );

  sdc_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .run(init_done), .ack(ref_ack), .pending(ref_pending)
  );

  sdc_sequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .BE_W(BE_W),
    .INIT_CYCLES(INIT_CYCLES), .INIT_REFS(INIT_REFS), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_RC(T_RC), .T_MRD(T_MRD), .T_WR(T_WR), .CAS_LAT(CAS_LAT)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_row(m_row), .req_bank(m_bank), .req_col(m_col), .req_wdata(req_wdata),
    .req_be(req_be), .ref_pending(ref_pending), .ref_ack(ref_ack),
    .req_ready(req_ready), .init_done(init_done), .cmd_q(cmd_q), .cke(sd_cke),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm), .dq_out(sd_dq_out),
    .dq_oe(sd_dq_oe)
  );

  sdc_read_capture #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .rd_issued(cmd_q == CMD_RD), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
endmodule

// File: rtl/sdram_ctl_checker.sv
module sdram_ctl_checker #(
  parameter int ROW_W   = 12,
  parameter int BE_W    = 8,
  parameter int CAS_LAT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic [BE_W-1:0]  sd_dqm,
  input logic             req_ready,
  input logic             init_done,
  input logic             rd_valid
);
  logic [3:0] code;
  logic is_nop, is_act, is_rd, is_wr, is_pre;

  assign code   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop = (code == 4'b0111);
  assign is_act = (code == 4'b0011);
  assign is_rd  = (code == 4'b0101);
  assign is_wr  = (code == 4'b0100);
  assign is_pre = (code == 4'b0010);

  AST_ACK_AFTER_INIT: assert property (@(posedge clk) disable iff (rst) req_ready |-> init_done); // R10
  AST_ACK_SINGLE:     assert property (@(posedge clk) disable iff (rst) req_ready |=> !req_ready); // R10
  AST_PRE_ALL_BANKS:  assert property (@(posedge clk) disable iff (rst) is_pre |-> sd_addr[10]); // R5
  AST_RW_NO_AUTOPRE:  assert property (@(posedge clk) disable iff (rst) (is_rd || is_wr) |-> !sd_addr[10]); // R5
  AST_ACT_GAP:        assert property (@(posedge clk) disable iff (rst) is_act |=> is_nop); // R5
  AST_RD_CAPTURE:     assert property (@(posedge clk) disable iff (rst) is_rd |-> ##(CAS_LAT+1) rd_valid); // R7
  AST_RD_MASK_LOW:    assert property (@(posedge clk) disable iff (rst) is_rd |-> (sd_dqm == '0)); // R7
  AST_ACCESS_AFTER_INIT: assert property (@(posedge clk) disable iff (rst) (is_act || is_rd || is_wr) |-> init_done); // R2
  AST_INIT_STICKY:    assert property (@(posedge clk) disable iff (rst) init_done |=> init_done); // R2
endmodule

bind sdram_ctl sdram_ctl_checker #(.ROW_W(ROW_W), .BE_W(BE_W), .CAS_LAT(CAS_LAT)) u_chk (
  .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .req_ready(req_ready),
  .init_done(init_done), .rd_valid(rd_valid)
);

// File: tb/sdram_ctl_bench.sv
module sdram_ctl_bench;
  localparam int INIT_CYCLES = 10000;
  localparam int INIT_REFS = 8;
  localparam int REF_INTERVAL = 1560;
  localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9, T_MRD = 2, T_WR = 1;
  localparam int CL = 3;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write;
  logic [22:0] req_addr;
  logic [63:0] req_wdata;
  logic [7:0] req_be;
  logic req_ready, rd_valid, init_done;
  logic [63:0] rd_data;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;
  logic [7:0] sd_dqm;
  logic [63:0] sd_dq_out, sd_dq_in;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  sdram_ctl u_sdram_ctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .init_done(init_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [63:0] exp_rd_q[$];
  logic [13:0] exp_act_q[$];
  logic [8:0]  exp_col_q[$];
  logic [63:0] shadow[int];

  // Behavioural memory and protocol monitor
  logic [63:0] mem[int];
  logic [63:0] rpd[4];
  logic        rpv[4];
  int cyc, t_pre, t_ref, t_mrs, t_wr, t_last_act, t_rd, nop_cnt, init_refs, norm_refs, prev_ref;
  bit open_b[4];
  logic [11:0] orow[4];
  int t_act[4];
  bit mrs_done, pre_seen, any_cmd;

  assign sd_dq_in = rpv[CL-1] ? rpd[CL-1] : 64'hDEAD_BEEF_DEAD_BEEF;

  always @(posedge clk) begin
    logic [3:0] c;
    int key;
    logic [13:0] ea;
    logic [8:0] ec;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    rpv[0] <= 1'b0;
    for (int i = 1; i < 4; i++) begin rpv[i] <= rpv[i-1]; rpd[i] <= rpd[i-1]; end
    if (rst) begin
      cyc = 0; t_pre = -1000; t_ref = -1000; t_mrs = -1000; t_wr = -1000; t_last_act = -1000;
      t_rd = -1000; nop_cnt = 0; init_refs = 0; norm_refs = 0; prev_ref = -1;
      mrs_done = 0; pre_seen = 0; any_cmd = 0;
      for (int i = 0; i < 4; i++) begin open_b[i] = 0; t_act[i] = -1000; end
    end else begin
      cyc++;
      if (cyc - t_rd <= CL - 2 && sd_dqm != 8'h00)
        check(0, "R7", "mask raised while read data pending", sd_dqm, 0);
      if (c[3] || c == 4'b0111) begin
        if (!any_cmd) begin
          nop_cnt++;
          if (nop_cnt > 2) check(sd_cke == 1'b1, "R1", "CKE high during settle", sd_cke, 1);
        end
      end else begin
        if (!any_cmd) begin
          any_cmd = 1;
          check(nop_cnt >= INIT_CYCLES, "R1", "NOP cycles before first command", nop_cnt, INIT_CYCLES);
        end
        if (mrs_done && t_mrs > 0 && cyc - t_mrs < T_MRD)
          check(0, "R2", "command too soon after mode load", cyc - t_mrs, T_MRD);
        case (c)
          4'b0010: begin
            check(sd_addr[10], "R5", "precharge A10", sd_addr[10], 1);
            for (int b = 0; b < 4; b++)
              if (open_b[b]) check(cyc - t_act[b] >= T_RAS, "R5", "ACT to PRE", cyc - t_act[b], T_RAS);
            check(cyc - t_wr > T_WR, "R5", "WRITE to PRE", cyc - t_wr, T_WR + 1);
            for (int b = 0; b < 4; b++) open_b[b] = 0;
            t_pre = cyc;
            if (!mrs_done) pre_seen = 1;
          end
          4'b0001: begin
            check(!(open_b[0] | open_b[1] | open_b[2] | open_b[3]), "R5", "refresh with open bank", 0, 0);
            check(cyc - t_pre >= T_RP, "R5", "PRE to REF", cyc - t_pre, T_RP);
            check(cyc - t_ref >= T_RC, "R2", "REF to REF", cyc - t_ref, T_RC);
            if (!mrs_done) begin
              check(pre_seen, "R2", "precharge before init refresh", pre_seen, 1);
              init_refs++;
            end else begin
              if (prev_ref >= 0)
                check(cyc - prev_ref <= REF_INTERVAL + 20, "R8", "refresh gap", cyc - prev_ref, REF_INTERVAL + 20);
              prev_ref = cyc;
              norm_refs++;
            end
            t_ref = cyc;
          end
          4'b0000: begin
            check(init_refs == INIT_REFS, "R2", "init refresh count", init_refs, INIT_REFS);
            check(sd_addr == 12'(CL << 4), "R2", "mode word", sd_addr, 12'(CL << 4));
            check(cyc - t_ref >= T_RC, "R2", "REF to mode load", cyc - t_ref, T_RC);
            mrs_done = 1;
            t_mrs = cyc;
          end
          4'b0011: begin
            check(mrs_done, "R2", "ACT before mode load", mrs_done, 1);
            check(!open_b[sd_ba], "R5", "ACT on open bank", open_b[sd_ba], 0);
            check(cyc - t_pre >= T_RP, "R5", "PRE to ACT", cyc - t_pre, T_RP);
            check(cyc - t_last_act >= T_RC, "R5", "ACT to ACT", cyc - t_last_act, T_RC);
            check(cyc - t_ref >= T_RC, "R9", "REF to ACT", cyc - t_ref, T_RC);
            if (exp_act_q.size() == 0) check(0, "R4", "unexpected ACT", {sd_ba, sd_addr}, 0);
            else begin
              ea = exp_act_q.pop_front();
              check({sd_ba, sd_addr} == ea, "R4", "ACT bank/row", {sd_ba, sd_addr}, ea);
            end
            open_b[sd_ba] = 1; orow[sd_ba] = sd_addr; t_act[sd_ba] = cyc; t_last_act = cyc;
          end
          4'b0100, 4'b0101: begin
            check(open_b[sd_ba], "R5", "column command on closed bank", open_b[sd_ba], 1);
            check(cyc - t_act[sd_ba] >= T_RCD, "R5", "ACT to column", cyc - t_act[sd_ba], T_RCD);
            check(!sd_addr[10], "R5", "column A10", sd_addr[10], 0);
            if (exp_col_q.size() == 0) check(0, "R4", "unexpected column", sd_addr, 0);
            else begin
              ec = exp_col_q.pop_front();
              check(sd_addr[8:0] == ec, "R4", "column", sd_addr[8:0], ec);
            end
            key = int'({sd_ba, orow[sd_ba], sd_addr[8:0]});
            if (!mem.exists(key)) mem[key] = 64'h0;
            if (c == 4'b0100) begin
              check(sd_dq_oe, "R6", "write output enable", sd_dq_oe, 1);
              for (int b = 0; b < 8; b++)
                if (!sd_dqm[b]) mem[key][8*b +: 8] = sd_dq_out[8*b +: 8];
              t_wr = cyc;
            end else begin
              check(sd_dqm == 8'h00, "R7", "read mask", sd_dqm, 0);
              rpv[0] <= 1'b1;
              rpd[0] <= mem[key];
              t_rd = cyc;
            end
          end
          default: check(0, "R3", "illegal command code", c, 4'b0111);
        endcase
      end
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    logic [63:0] e;
    if (!rst) begin
      if (req_ready) check(init_done, "R10", "ack before init", init_done, 1);
      if (rd_valid) begin
        if (exp_rd_q.size() == 0) check(0, "R7", "unexpected read data", rd_data, 0);
        else begin
          e = exp_rd_q.pop_front();
          check(rd_data == e, "R7", "read data", rd_data, e);
        end
      end
    end
  end

  task automatic do_req(input bit wr, input logic [22:0] a, input logic [63:0] d, input logic [7:0] be);
    int k;
    k = int'(a);
    exp_act_q.push_back({a[10:9], a[22:11]});
    exp_col_q.push_back(a[8:0]);
    if (!shadow.exists(k)) shadow[k] = 64'h0;
    if (wr) begin
      for (int b = 0; b < 8; b++) if (be[b]) shadow[k][8*b +: 8] = d[8*b +: 8];
    end else exp_rd_q.push_back(shadow[k]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b0;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [22:0] pool[16];
    rst = 1'b1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (5) @(negedge clk);
    check(init_done == 0 && req_ready == 0, "R1", "reset outputs", {init_done, req_ready}, 0);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command NOP",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    rst = 1'b0;
    // R10: request held through initialization
    do_req(1, {12'hABC, 2'd1, 9'h055}, 64'h0123_4567_89AB_CDEF, 8'hFF);
    check(init_done, "R10", "init done at first ack", init_done, 1);
    check(cyc >= INIT_CYCLES, "R10", "first ack time", cyc, INIT_CYCLES);
    do_req(0, {12'hABC, 2'd1, 9'h055}, 0, 0);
    // R4: corners of the address split
    do_req(1, {12'hFFF, 2'd3, 9'h1FF}, 64'hFFFF_0000_FFFF_0000, 8'hFF);
    do_req(1, {12'h800, 2'd0, 9'h000}, 64'h1111_2222_3333_4444, 8'hFF);
    do_req(1, {12'h000, 2'd2, 9'h100}, 64'h5555_6666_7777_8888, 8'hFF);
    do_req(0, {12'hFFF, 2'd3, 9'h1FF}, 0, 0);
    do_req(0, {12'h800, 2'd0, 9'h000}, 0, 0);
    do_req(0, {12'h000, 2'd2, 9'h100}, 0, 0);
    // R6: partial and empty byte enables
    do_req(1, {12'h123, 2'd2, 9'h0AA}, 64'hAAAA_AAAA_AAAA_AAAA, 8'hFF);
    do_req(1, {12'h123, 2'd2, 9'h0AA}, 64'h0102_0304_0506_0708, 8'h0F);
    do_req(0, {12'h123, 2'd2, 9'h0AA}, 0, 0);
    do_req(1, {12'h123, 2'd2, 9'h0AA}, 64'h9999_9999_9999_9999, 8'h00);
    do_req(0, {12'h123, 2'd2, 9'h0AA}, 0, 0);
    do_req(1, {12'h123, 2'd2, 9'h0AA}, 64'hC3C3_C3C3_C3C3_C3C3, 8'hA5);
    do_req(0, {12'h123, 2'd2, 9'h0AA}, 0, 0);
    // R8, R9: continuous traffic across several refresh intervals
    for (int i = 0; i < 16; i++) pool[i] = 23'($urandom);
    for (int i = 0; i < 600; i++) begin
      int p;
      p = i % 16;
      if (i < 16 || ($urandom % 2) == 0)
        do_req(1, pool[p], {$urandom, $urandom}, 8'($urandom));
      else
        do_req(0, pool[p], 0, 0);
    end
    repeat (40) @(negedge clk);
    check(exp_rd_q.size() == 0, "R7", "reads outstanding", exp_rd_q.size(), 0);
    check(exp_act_q.size() == 0, "R4", "activates outstanding", exp_act_q.size(), 0);
    check(norm_refs >= 2, "R9", "refreshes under traffic", norm_refs, 2);
    check(norm_refs >= (cyc - INIT_CYCLES) / (REF_INTERVAL + 20) - 1, "R8", "refresh count",
          norm_refs, (cyc - INIT_CYCLES) / (REF_INTERVAL + 20) - 1);
    finish_up();
  end
endmodule